// File: doc/BRIEF.md
# 16/32-bit FIFO Port Width Adapter

This block joins a 32-bit FIFO to a local data bus whose width is chosen at run time by a bus-width select input. When the local bus is 32 bits wide, each access moves a whole word, with byte enables marking the bytes it carries. When the bus is 16 bits wide, the top byte-enable pin acts as address bit 1 and picks the low or the high half-word. The two low byte enables then mark bytes within that half. Writes are merged into a 32-bit holding word before they enter the FIFO. Reads return the selected half of the FIFO head word, right-aligned.

An access moves the FIFO (push for writes, pop for reads) only when the set of bytes it touches includes a programmable advance lane (0 to 3). Setting the lane to 0 gives a plain byte-wide port, and setting it to 1 gives a plain half-word port. For 16-bit assembly, where the low half always comes first, the lane must be 2 or 3. If the lane is left at 0, the FIFO moves after the low half, and the high half spills into the following entry.

Top module: `fifo_width_adapter`

## Requirements
- R1: After reset, rdata and overflow are 0 and the write holding word is empty, so the first pushed entry carries only bytes written after reset.
- R2: In 32-bit mode (narrow=0), a write whose byte enables include the advance lane pushes one entry. The entry holds the written bytes, plus any bytes held from earlier writes, and zeros in every other byte lane.
- R3: A write that does not touch the advance lane does not push. Its bytes are held and merged into the entry pushed by a later write.
- R4: In 16-bit mode (narrow=1), be[3]=0 selects bits 15:0 and be[3]=1 selects bits 31:16. be[1:0] enable the two bytes of that half, wdata[15:0] carries the data, and be[2] is ignored. With the advance lane at 3, a low-half write followed by a high-half write pushes a single entry {high, low}.
- R5: In 16-bit mode, a read returns the selected half of the FIFO head in rdata[15:0], with rdata[31:16]=0, one cycle after the strobe. It pops only if the selected lanes include the advance lane.
- R6: In 32-bit mode, a read returns the whole head word one cycle after the strobe. It pops only if be includes the advance lane.
- R7: In 16-bit mode with the advance lane at 0, each low-half write pushes. A following high-half write is held and lands in the upper half of the next entry.
- R8: With the advance lane at 0, a 32-bit-mode write with be=0001 pushes an entry with only byte 0 set. With the advance lane at 1, each 16-bit low-half read pops.
- R9: A write strobe while fifo_full is high changes nothing and does not push. It sets overflow, which stays at 1 until reset.
- R10: A read strobe while fifo_empty is high leaves rdata unchanged and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow | input | 1 | 0: 32-bit local bus, 1: 16-bit local bus |
| adv_lane | input | 2 | Byte lane whose access moves the FIFO |
| wr_stb | input | 1 | Local write strobe, one access per cycle |
| rd_stb | input | 1 | Local read strobe, one access per cycle |
| be | input | 4 | Byte enables; in 16-bit mode be[3] is address bit 1 |
| wdata | input | 32 | Local write data |
| rdata | output | 32 | Local read data, registered |
| overflow | output | 1 | Sticky flag for a write attempted while full |
| fifo_push | output | 1 | Push strobe to the FIFO |
| fifo_wdata | output | 32 | Word pushed to the FIFO |
| fifo_full | input | 1 | FIFO full |
| fifo_pop | output | 1 | Pop strobe to the FIFO |
| fifo_rdata | input | 32 | FIFO head word, valid while not empty |
| fifo_empty | input | 1 | FIFO empty |

## Verification
The assertions assume a FIFO whose head word is valid while fifo_empty is low and whose full and empty flags are updated at the clock edge that follows a push or a pop. They also assume that the local side never raises write and read strobes in the same cycle. The bench models a four-entry FIFO of exactly that kind and drives one strobe at a time on the falling edge. Its stimulus deliberately includes writes when the FIFO is full and reads when it is empty, so the guarded cases are exercised rather than avoided.

// File: rtl/fwa_pkg.sv
package fwa_pkg;
    localparam int WORD_W     = 32;
    localparam int LANE_W     = 8;
    localparam int LANES      = WORD_W / LANE_W;
    localparam int HALF_W     = WORD_W / 2;
    localparam int HALF_LANES = LANES / 2;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic {
        BUS_WIDE   = 1'b0,
        BUS_NARROW = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic [LANES-1:0]  lanes;
        logic [WORD_W-1:0] data;
    } access_t;

    // Byte lanes of the 32-bit word touched by one local access.
    function automatic logic [LANES-1:0] touched_lanes(input bus_mode_e mode,
                                                      input logic [LANES-1:0] be);
        logic [LANES-1:0] l;
        if (mode == BUS_NARROW) begin
            if (be[LANES-1])
                l = {be[HALF_LANES-1:0], {HALF_LANES{1'b0}}};
            else
                l = {{HALF_LANES{1'b0}}, be[HALF_LANES-1:0]};
        end else begin
            l = be;
        end
        return l;
    endfunction

    // Place local write data on the 32-bit word lanes.
    function automatic access_t steer_write(input bus_mode_e mode,
                                            input logic [LANES-1:0] be,
                                            input logic [WORD_W-1:0] wd);
        access_t a;
        a.lanes = touched_lanes(mode, be);
        if (mode == BUS_NARROW)
            a.data = {wd[HALF_W-1:0], wd[HALF_W-1:0]};
        else
            a.data = wd;
        return a;
    endfunction
endpackage

// File: rtl/fwa_write_path.sv
module fwa_write_path
    import fwa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  bus_mode_e             mode,
    input  logic [LANE_IDX_W-1:0] adv_lane,
    input  logic                  wr_stb,
    input  logic [LANES-1:0]      be,
    input  logic [WORD_W-1:0]     wdata,
    input  logic                  fifo_full,
    output logic                  fifo_push,
    output logic [WORD_W-1:0]     fifo_wdata,
    output logic                  overflow
);
    access_t           acc;
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] merged;
    logic              accept;
    logic              advance;
    logic              ovf_q;

    assign acc = steer_write(mode, be, wdata);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] = acc.lanes[g] ? acc.data[g*LANE_W +: LANE_W]
                                                         : hold_q[g*LANE_W +: LANE_W];
    end

    assign accept     = wr_stb && !fifo_full;
    assign advance    = acc.lanes[adv_lane];
    assign fifo_push  = accept && advance;
    assign fifo_wdata = merged;
    assign overflow   = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_stb && fifo_full)
                ovf_q <= 1'b1;
            if (accept)
                hold_q <= advance ? '0 : merged;
        end
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        wr_stb && fifo_full |=> overflow); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9
    AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fifo_push); // R9
    AST_LOW_HALF_HELD: assert property (@(posedge clk) disable iff (rst)
        mode == BUS_NARROW && wr_stb && !be[LANES-1] && adv_lane[LANE_IDX_W-1] |-> !fifo_push); // R4
    AST_HOLD_EMPTY_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> hold_q == '0); // R2
endmodule

// File: rtl/fwa_read_path.sv
module fwa_read_path
    import fwa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  bus_mode_e             mode,
    input  logic [LANE_IDX_W-1:0] adv_lane,
    input  logic                  rd_stb,
    input  logic [LANES-1:0]      be,
    input  logic [WORD_W-1:0]     fifo_rdata,
    input  logic                  fifo_empty,
    output logic                  fifo_pop,
    output logic [WORD_W-1:0]     rdata
);
    logic [LANES-1:0]  lanes;
    logic [WORD_W-1:0] view;
    logic [HALF_W-1:0] half_sel;
    logic              take;
    logic [WORD_W-1:0] rdata_q;

    assign lanes    = touched_lanes(mode, be);
    assign half_sel = be[LANES-1] ? fifo_rdata[WORD_W-1:HALF_W] : fifo_rdata[HALF_W-1:0];
    assign view     = (mode == BUS_NARROW) ? {{(WORD_W-HALF_W){1'b0}}, half_sel} : fifo_rdata;
    assign take     = rd_stb && !fifo_empty;
    assign fifo_pop = take && lanes[adv_lane];
    assign rdata    = rdata_q;

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (take)
            rdata_q <= view;
    end

    AST_EMPTY_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        rd_stb && fifo_empty |=> $stable(rdata)); // R10
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_pop); // R10
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_stb && mode == BUS_NARROW && !fifo_empty |=> rdata[WORD_W-1:HALF_W] == '0); // R5
endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter
    import fwa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  narrow,
    input  logic [LANE_IDX_W-1:0] adv_lane,
    input  logic                  wr_stb,
    input  logic                  rd_stb,
    input  logic [LANES-1:0]      be,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic                  overflow,
    output logic                  fifo_push,
    output logic [WORD_W-1:0]     fifo_wdata,
    input  logic                  fifo_full,
    output logic                  fifo_pop,
    input  logic [WORD_W-1:0]     fifo_rdata,
    input  logic                  fifo_empty
);
    bus_mode_e mode;
    assign mode = narrow ? BUS_NARROW : BUS_WIDE;

    fwa_write_path u_wr (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .adv_lane   (adv_lane),
        .wr_stb     (wr_stb),
        .be         (be),
        .wdata      (wdata),
        .fifo_full  (fifo_full),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .overflow   (overflow)
    );

    fwa_read_path u_rd (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .adv_lane   (adv_lane),
        .rd_stb     (rd_stb),
        .be         (be),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .fifo_pop   (fifo_pop),
        .rdata      (rdata)
    );

    AST_NO_PUSH_POP_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb) |-> !(fifo_push && fifo_pop)); // R2
endmodule

// File: tb/fifo_width_adapter_test.sv
module fifo_width_adapter_test;
    localparam int CLK_PER = 10;
    localparam int DEPTH   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        narrow = 1'b0;
    logic [1:0]  adv_lane = 2'd0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [3:0]  be = 4'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        overflow;
    logic        fifo_push;
    logic [31:0] fifo_wdata;
    logic        fifo_full;
    logic        fifo_pop;
    logic [31:0] fifo_rdata;
    logic        fifo_empty;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] exp_w[$];
    logic [31:0] exp_r[$];
    string       tag_w[$];
    string       tag_r[$];

    // FIFO model
    logic [31:0] mem [DEPTH];
    logic [1:0]  wp, rp;
    int          cnt;
    assign fifo_full  = (cnt == DEPTH);
    assign fifo_empty = (cnt == 0);
    assign fifo_rdata = mem[rp];

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= 0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (fifo_push) begin mem[wp] <= fifo_wdata; wp <= wp + 2'd1; end
            if (fifo_pop) rp <= rp + 2'd1;
            cnt <= cnt + int'(fifo_push) - int'(fifo_pop);
        end
    end

    fifo_width_adapter uut (
        .clk(clk), .rst(rst), .narrow(narrow), .adv_lane(adv_lane),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .be(be), .wdata(wdata),
        .rdata(rdata), .overflow(overflow), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    // Monitor: compares pushes and read data with the scoreboard queues.
    bit rd_seen = 1'b0;
    always begin
        @(negedge clk);
        #(CLK_PER/4);
        if (!rst) begin
            if (rd_seen) begin
                if (exp_r.size() == 0) chk(1'b0, "R5/R6 no expected read", rdata, '0);
                else chk(rdata == exp_r[0], tag_r[0], rdata, exp_r[0]);
                if (exp_r.size() != 0) begin void'(exp_r.pop_front()); void'(tag_r.pop_front()); end
            end
            if (fifo_push) begin
                if (exp_w.size() == 0) chk(1'b0, "R3/R9 unexpected push", fifo_wdata, '0);
                else chk(fifo_wdata == exp_w[0], tag_w[0], fifo_wdata, exp_w[0]);
                if (exp_w.size() != 0) begin void'(exp_w.pop_front()); void'(tag_w.pop_front()); end
            end
            rd_seen = rd_stb;
        end else begin
            rd_seen = 1'b0;
        end
    end

    task automatic wr(input bit n, input logic [1:0] adv, input logic [3:0] b,
                      input logic [31:0] d, input bit pushes, input logic [31:0] e, input string tag);
        @(negedge clk);
        narrow = n; adv_lane = adv; be = b; wdata = d; wr_stb = 1'b1;
        if (pushes) begin exp_w.push_back(e); tag_w.push_back(tag); end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input bit n, input logic [1:0] adv, input logic [3:0] b,
                      input logic [31:0] e, input string tag);
        @(negedge clk);
        narrow = n; adv_lane = adv; be = b; rd_stb = 1'b1;
        exp_r.push_back(e); tag_r.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic chk_cnt(input int e, input string tag);
        @(negedge clk);
        #(CLK_PER/4);
        chk(cnt == e, tag, cnt, e);
    endtask

    initial begin
        #(CLK_PER * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #(CLK_PER/4);
        chk(rdata == '0, "R1 rdata after reset", rdata, '0);
        chk(overflow == 1'b0, "R1 overflow after reset", {31'b0, overflow}, '0);
        chk(fifo_push == 1'b0, "R1 no push after reset", {31'b0, fifo_push}, '0);

        // 32-bit writes
        wr(0, 2'd0, 4'b1111, 32'h11223344, 1, 32'h11223344, "R2 full word push");
        wr(0, 2'd3, 4'b0011, 32'hAAAA5566, 0, '0, "R3");
        wr(0, 2'd3, 4'b1100, 32'h7788BBBB, 1, 32'h77885566, "R3 merged entry");
        wr(0, 2'd2, 4'b0100, 32'hFFFFFFFF, 1, 32'h00FF0000, "R2 unused lanes zero");
        chk_cnt(3, "R2/R3 fifo count");

        // 32-bit reads
        rd(0, 2'd0, 4'b0001, 32'h11223344, "R6 read pops");
        rd(0, 2'd0, 4'b1110, 32'h77885566, "R6 read without advance lane");
        chk_cnt(2, "R6 no pop without advance lane");
        rd(0, 2'd0, 4'b1111, 32'h77885566, "R6 read pops");
        rd(0, 2'd0, 4'b1111, 32'h00FF0000, "R6 read last");
        rd(0, 2'd0, 4'b1111, 32'h00FF0000, "R10 empty read keeps rdata");
        chk_cnt(0, "R10 fifo count after empty read");

        // 16-bit assembly with advance lane 3
        wr(1, 2'd3, 4'b0011, 32'h00001234, 0, '0, "R4");
        wr(1, 2'd3, 4'b1011, 32'h00005678, 1, 32'h56781234, "R4 half assembly");
        // advance lane 0 in 16-bit mode: shifting hazard
        wr(1, 2'd0, 4'b0011, 32'h0000AAAA, 1, 32'h0000AAAA, "R7 early push");
        wr(1, 2'd0, 4'b1011, 32'h0000BBBB, 0, '0, "R7");
        wr(1, 2'd0, 4'b0011, 32'h0000CCCC, 1, 32'hBBBBCCCC, "R7 shifted entry");
        // byte-wide use
        wr(0, 2'd0, 4'b0001, 32'h123456EE, 1, 32'h000000EE, "R8 byte entry");
        chk_cnt(4, "R4/R7/R8 fifo count");

        // write while full
        wr(0, 2'd0, 4'b1111, 32'hDEADBEEF, 0, '0, "R9");
        chk(overflow == 1'b1, "R9 overflow set", {31'b0, overflow}, 32'd1);
        chk_cnt(4, "R9 full write ignored");

        // 16-bit reads
        rd(1, 2'd3, 4'b0011, 32'h00001234, "R5 low half");
        chk_cnt(4, "R5 low half no pop");
        rd(1, 2'd3, 4'b1011, 32'h00005678, "R5 high half pops");
        rd(1, 2'd1, 4'b0011, 32'h0000AAAA, "R8 half-word read pops");
        chk_cnt(2, "R5/R8 fifo count");
        rd(0, 2'd0, 4'b1111, 32'hBBBBCCCC, "R6 read");
        rd(0, 2'd0, 4'b1111, 32'h000000EE, "R6 read");
        rd(1, 2'd3, 4'b1011, 32'h000000EE, "R10 empty narrow read keeps rdata");
        chk_cnt(0, "R10 fifo count");
        chk(overflow == 1'b1, "R9 overflow sticky", {31'b0, overflow}, 32'd1);

        // leave a held byte, then reset
        wr(0, 2'd0, 4'b0010, 32'h00009900, 0, '0, "R3");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #(CLK_PER/4);
        chk(overflow == 1'b0, "R1 overflow cleared by reset", {31'b0, overflow}, '0);
        chk(rdata == '0, "R1 rdata cleared by reset", rdata, '0);
        wr(0, 2'd0, 4'b0001, 32'hFFFFFF42, 1, 32'h00000042, "R1 hold cleared by reset");
        rd(0, 2'd0, 4'b0001, 32'h00000042, "R6 read after reset");
        chk_cnt(0, "R1/R6 fifo count");

        repeat (2) @(negedge clk);
        chk(exp_w.size() == 0, "R2 pending pushes", exp_w.size(), 0);
        chk(exp_r.size() == 0, "R5 pending reads", exp_r.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule